// File: doc/BRIEF.md
# Time-Slot Interchange Core

This block moves 8-bit channel samples between the positions of a 32-slot time-division frame. One sample arrives per clock, already parallel, with a frame pulse that marks slot 0. Every sample is stored in a data memory under the number of the slot it arrived in. A connection memory has one entry per output channel and names the source channel for that output. For each output slot the block fetches the named sample and presents it on a registered parallel output, together with the output channel number.

Two delay disciplines are available, chosen by a mode input. Variable mode gives the lowest latency: a sample leaves in the current frame whenever its source slot lies at least three slots ahead of the output slot, and otherwise it leaves one frame later. Constant mode rotates three data-memory banks, so every sample leaves exactly two frames after the frame it arrived in. The whole frame then moves as a unit, whatever the channel pairing. The mode is sampled once per frame, at the first slot.

Top module: `tsi_core`

## Requirements
- R1: While reset is held, and after reset until the first frame pulse, `out_valid` is 0. The reset value of `out_data` is 0. A frame pulse marks the cycle that carries the sample of slot 0 and starts the slot count.
- R2: Once started, the slot count runs 0 to 31 and wraps from 31 to 0 by itself when no frame pulse comes. The output channel numbers then continue without a gap.
- R3: Output channel m appears on `out_slot` exactly 3 clocks after the input sample of slot m. The first `out_valid` comes 3 clocks after the first frame pulse. `out_frame_start` is 1 exactly when `out_slot` is 0, and `out_valid` stays 1 from then on.
- R4: In variable mode (`mode_sel` = 0), when the source channel n satisfies n + 3 <= m, output channel m of frame F carries the sample of slot n from frame F. This gives the three-slot minimum delay.
- R5: In variable mode, when m is n, n+1 or n+2, output channel m of frame F carries the sample of slot n from frame F-1.
- R6: In variable mode, when m < n, output channel m of frame F carries the sample of slot n from frame F-1.
- R7: In constant mode (`mode_sel` = 1), output channel m of frame F carries the sample of slot n from frame F-2 for every pair (n, m). This holds at the extremes n=31, m=0 and n=0, m=31.
- R8: The mode that governs output frame F is the value of `mode_sel` in the cycle that carries input slot 0 of frame F. A change of `mode_sel` later in the frame has no effect until the next frame start.
- R9: A write of source n to connection entry m (`cm_we`, `cm_addr` = m, `cm_src` = n) is used from the next fetch of output channel m. A write made in the same cycle as input slot m is first used in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | Marks the cycle carrying input slot 0 |
| in_data | input | 8 | Input sample for the current slot |
| mode_sel | input | 1 | 0 = variable delay, 1 = constant delay; sampled at frame start |
| cm_we | input | 1 | Connection memory write enable |
| cm_addr | input | 5 | Output channel whose entry is written |
| cm_src | input | 5 | Source channel stored for that output |
| out_valid | output | 1 | Output sample valid |
| out_frame_start | output | 1 | Output slot is channel 0 |
| out_slot | output | 5 | Output channel number |
| out_data | output | 8 | Switched output sample |

## Verification
The bench builds the core with its default values: 32 slots and 8-bit samples. At this size all 32 output channels of every frame can be predicted, because each input sample encodes its own frame and slot. Eight connection maps cover the pairings where the source is equal to the output, one or two slots before it, three slots before it (the minimum in-frame lead), reversed, scrambled, and all taken from channel 0 or channel 31. The mode alternates every three frames and is toggled in the middle of each frame, so every map runs in both disciplines and across mode changes. One frame in four arrives without a pulse, which tests the free-running wrap.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic {
    DLY_VARIABLE = 1'b0,
    DLY_CONSTANT = 1'b1
  } dly_mode_e;

  // constant mode holds each frame this many frames before reading it out
  localparam int HOLD_FRAMES = 2;
  localparam int NBANKS      = HOLD_FRAMES + 1;
  localparam int BANK_W      = $clog2(NBANKS);
  // variable mode: minimum slot lead for an in-frame read
  localparam int MIN_LEAD    = 3;

  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
  import tsi_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int DATA_W = 8,
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_pulse,
  input  logic [DATA_W-1:0] in_data,
  input  logic              mode_sel,
  output logic [SW-1:0]     nxt_slot,
  output logic [SW-1:0]     slot_q,
  output bank_t             wbank_q,
  output dly_mode_e         mode_q,
  output logic              live_q,
  output logic [DATA_W-1:0] data_q
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic wrap;
  logic advance;

  assign wrap     = (slot_q == LAST);
  assign nxt_slot = (frame_pulse || wrap) ? '0 : slot_q + 1'b1;
  assign advance  = frame_pulse || (live_q && wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= 1'b0;
      slot_q  <= '0;
      wbank_q <= '0;
      mode_q  <= DLY_VARIABLE;
      data_q  <= '0;
    end else begin
      data_q <= in_data;
      if (frame_pulse) live_q <= 1'b1;
      if (live_q || frame_pulse) slot_q <= nxt_slot;
      if (advance) begin
        wbank_q <= (wbank_q == bank_t'(NBANKS - 1)) ? bank_t'(0) : wbank_q + bank_t'(1);
        mode_q  <= dly_mode_e'(mode_sel);
      end
    end
  end

  a_r1_pulse_aligns: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |=> (live_q && slot_q == '0));
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (live_q && wrap && !frame_pulse) |=> (slot_q == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (live_q && !wrap && !frame_pulse) |=> (slot_q == $past(slot_q) + 1'b1));
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(mode_q));
  a_r7_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(wbank_q));
  a_r7_bank_range: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (wbank_q < bank_t'(NBANKS)));
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int SLOTS = 32,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [SW-1:0] wsrc,
  input  logic [SW-1:0] raddr,
  output logic [SW-1:0] rsrc_q
);
  logic [SW-1:0] map_mem [SLOTS];

  // read-before-write on the same address: the old entry is returned
  always_ff @(posedge clk) begin
    if (we) map_mem[waddr] <= wsrc;
    rsrc_q <= map_mem[raddr];
  end
endmodule

// File: rtl/tsi_read_sel.sv
module tsi_read_sel
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int SW   = $clog2(SLOTS)
) (
  input  dly_mode_e     mode,
  input  logic [SW-1:0] slot,
  input  logic [SW-1:0] src,
  input  bank_t         wbank,
  output bank_t         rd_bank
);
  bank_t oldest;
  bank_t previous;
  logic  in_frame;

  always_comb begin
    oldest   = (wbank == bank_t'(NBANKS - 1)) ? bank_t'(0) : wbank + bank_t'(1);
    previous = (wbank == bank_t'(0)) ? bank_t'(NBANKS - 1) : wbank - bank_t'(1);
    in_frame = ({1'b0, src} + (SW+1)'(MIN_LEAD)) <= {1'b0, slot};
    if (mode == DLY_CONSTANT) rd_bank = oldest;
    else if (in_frame)        rd_bank = wbank;
    else                      rd_bank = previous;
  end
endmodule

// File: rtl/tsi_bank_mem.sv
module tsi_bank_mem
  import tsi_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int DATA_W = 8,
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  bank_t             wr_bank,
  input  logic [SW-1:0]     wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  bank_t             rd_bank,
  input  logic [SW-1:0]     rd_slot,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] bank_rd [NBANKS];
  bank_t             rd_bank_q;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [DATA_W-1:0] cells [SLOTS];
    logic [DATA_W-1:0] rq;
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == bank_t'(b)) cells[wr_slot] <= wr_data;
      rq <= cells[rd_slot];
    end
    assign bank_rd[b] = rq;
  end

  always_ff @(posedge clk) rd_bank_q <= rd_bank;

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBANKS; b++)
      if (rd_bank_q == bank_t'(b)) rd_data = bank_rd[b];
  end

  // R4: an in-frame read never targets the cell being written this cycle
  a_r4_no_collision: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_bank == wr_bank) |-> (rd_slot != wr_slot));
endmodule

// File: rtl/tsi_core.sv
module tsi_core
  import tsi_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int DATA_W = 8,
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_pulse,
  input  logic [DATA_W-1:0] in_data,
  input  logic              mode_sel,
  input  logic              cm_we,
  input  logic [SW-1:0]     cm_addr,
  input  logic [SW-1:0]     cm_src,
  output logic              out_valid,
  output logic              out_frame_start,
  output logic [SW-1:0]     out_slot,
  output logic [DATA_W-1:0] out_data
);
  logic [SW-1:0]     nxt_slot;
  logic [SW-1:0]     slot_q;
  bank_t             wbank_q;
  dly_mode_e         mode_q;
  logic              live_q;
  logic [DATA_W-1:0] data_q;
  logic [SW-1:0]     src_q;
  bank_t             rd_bank;
  logic [DATA_W-1:0] rd_data;
  logic              valid_b;
  logic [SW-1:0]     slot_b;

  tsi_slot_timer #(.SLOTS(SLOTS), .DATA_W(DATA_W)) i_timer (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .in_data(in_data),
    .mode_sel(mode_sel), .nxt_slot(nxt_slot), .slot_q(slot_q),
    .wbank_q(wbank_q), .mode_q(mode_q), .live_q(live_q), .data_q(data_q)
  );

  tsi_conn_mem #(.SLOTS(SLOTS)) i_conn (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wsrc(cm_src),
    .raddr(nxt_slot), .rsrc_q(src_q)
  );

  tsi_read_sel #(.SLOTS(SLOTS)) i_sel (
    .mode(mode_q), .slot(slot_q), .src(src_q), .wbank(wbank_q), .rd_bank(rd_bank)
  );

  tsi_bank_mem #(.SLOTS(SLOTS), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .rst(rst), .wr_en(live_q), .wr_bank(wbank_q), .wr_slot(slot_q),
    .wr_data(data_q), .rd_bank(rd_bank), .rd_slot(src_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_b         <= 1'b0;
      slot_b          <= '0;
      out_valid       <= 1'b0;
      out_frame_start <= 1'b0;
      out_slot        <= '0;
      out_data        <= '0;
    end else begin
      valid_b         <= live_q;
      slot_b          <= slot_q;
      out_valid       <= valid_b;
      out_frame_start <= valid_b && (slot_b == '0);
      out_slot        <= slot_b;
      out_data        <= rd_data;
    end
  end

  a_r5_close_source_prev: assert property (@(posedge clk) disable iff (rst)
    (live_q && mode_q == DLY_VARIABLE && ({1'b0, src_q} + (SW+1)'(MIN_LEAD)) > {1'b0, slot_q})
      |-> (rd_bank != wbank_q));
  a_r7_const_not_current: assert property (@(posedge clk) disable iff (rst)
    (live_q && mode_q == DLY_CONSTANT) |-> (rd_bank != wbank_q));
  a_r3_valid_stays: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);
  a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (rst)
    !live_q |=> !valid_b);
endmodule

// File: tb/test_tsi_core.sv
`timescale 1ns/1ps
module test_tsi_core;
  localparam int SLOTS  = 32;
  localparam int DATA_W = 8;
  localparam int SW     = 5;
  localparam int NMAPS  = 8;
  localparam int LASTF  = 40;

  logic clk = 1'b0;
  logic rst;
  logic frame_pulse, mode_sel, cm_we;
  logic [DATA_W-1:0] in_data;
  logic [SW-1:0] cm_addr, cm_src;
  logic out_valid, out_frame_start;
  logic [SW-1:0] out_slot;
  logic [DATA_W-1:0] out_data;

  int compared = 0, mismatched = 0, cyc = 0, pulse_cyc = 0;
  bit pulse_given = 0, seen_valid = 0, done = 0;
  int ofr = -1, exp_slot = 0;
  int mode_of [64];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tsi_core #(.SLOTS(SLOTS), .DATA_W(DATA_W)) i_tsi_core (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .in_data(in_data),
    .mode_sel(mode_sel), .cm_we(cm_we), .cm_addr(cm_addr), .cm_src(cm_src),
    .out_valid(out_valid), .out_frame_start(out_frame_start),
    .out_slot(out_slot), .out_data(out_data)
  );

  function automatic int gen(int f, int n);
    return (f * 29 + n * 11 + 7) % 256;
  endfunction

  function automatic int src_of(int k, int m);
    case (k)
      0: return m;
      1: return (m + 31) % 32;
      2: return (m + 30) % 32;
      3: return (m + 29) % 32;
      4: return 31 - m;
      5: return (m * 7 + 3) % 32;
      6: return 0;
      default: return 31;
    endcase
  endfunction

  task automatic check(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (frame %0d)", req, act, expv, ofr);
    end
  endtask

  // stimulus
  initial begin
    rst = 1'b1; frame_pulse = 0; in_data = 0; mode_sel = 0;
    cm_we = 0; cm_addr = 0; cm_src = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset data", int'(out_data), 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (6) begin @(posedge clk); #1; end
    for (int f = 0; f <= LASTF + 1; f++) begin
      for (int s = 0; s < SLOTS; s++) begin
        frame_pulse = (s == 0) && (f % 4 != 3);   // R2: every fourth frame has no pulse
        if (s == 0) begin
          mode_of[f] = (f / 3) % 2;
          mode_sel = mode_of[f][0];
        end
        if (s == 17) mode_sel = ~mode_sel;        // R8: mid-frame change must be ignored
        in_data = DATA_W'(gen(f, s));
        cm_we   = (f % 5 == 0) && (f / 5 < NMAPS); // R9: reload map during frame 5k
        cm_addr = SW'(s);
        cm_src  = SW'(src_of(f / 5, s));
        if (f == 0 && s == 0) begin pulse_cyc = cyc; pulse_given = 1; end
        @(posedge clk); #1;
      end
    end
    frame_pulse = 0; cm_we = 0;
    repeat (10) @(posedge clk);
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (!seen_valid && !out_valid && !pulse_given)
        check("R1 no output before first pulse", int'(out_valid), 0);
      if (out_valid) begin
        if (!seen_valid) begin
          seen_valid = 1;
          check("R3 first output latency", cyc - pulse_cyc, 3);
        end
        check("R2 output channel sequence", int'(out_slot), exp_slot);
        check("R3 frame start flag", int'(out_frame_start), int'(exp_slot == 0));
        if (exp_slot == 0) ofr++;
        if (ofr >= 2 && ofr <= LASTF) begin
          automatic int k = (ofr - 1) / 5;
          automatic int m = exp_slot;
          automatic int n = src_of(k, m);
          automatic int expv;
          automatic string tag;
          if (mode_of[ofr] == 1) begin
            expv = gen(ofr - 2, n); tag = "R7";
          end else if (n + 3 <= m) begin
            expv = gen(ofr, n); tag = "R4";
          end else if (m >= n) begin
            expv = gen(ofr - 1, n); tag = "R5";
          end else begin
            expv = gen(ofr - 1, n); tag = "R6";
          end
          tag = {tag, " with R8 mode latch"};
          if (ofr % 5 == 1) tag = {tag, " R9 new map"};
          check($sformatf("%s ch %0d src %0d", tag, m, n), int'(out_data), expv);
          if (ofr == LASTF && m == SLOTS - 1) done = 1;
        end
        exp_slot = (exp_slot + 1) % SLOTS;
      end
    end
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule